// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides whether an arriving frame is kept or dropped, using only its 48-bit destination address. The receiver hands it the destination bytes one per strobe, first byte marked with a start flag, and idle cycles may fall between bytes. One cycle after the last destination byte the block raises a single-cycle strobe that carries the verdict.

Four classes of address are told apart. The all-ones broadcast address follows a reject bit. Any other address whose first byte has its least significant bit set is a group address, and it is looked up in a 64-bin hash table. The bin is picked by the top six bits of the Ethernet CRC-32 over the six address bytes. Everything else is an individual address and must equal the programmed station address in all 48 bits. A promiscuous bit overrides all of these. A plain write port loads the station address, the two halves of the hash table and the mode bits.

Top module: `rx_da_filter`

## Requirements
- R1: After reset every configuration register is zero and `dec_vld` is low. With that state an all-zero individual address is accepted, broadcast is accepted and every group address is rejected.
- R2: `dec_vld` is high for exactly one cycle, in the cycle after the sixth accepted destination byte. Gaps in `byte_vld` between bytes are allowed. Bytes that arrive after the sixth and before the next `byte_sof` are ignored and raise no strobe.
- R3: Writes use select 0 for the low station word and select 1 for the high station word. The low word holds address bytes 2..5 (byte 2 in bits 31:24, byte 5 in bits 7:0). The high word holds bytes 0 and 1 (byte 0 in bits 15:8, byte 1 in bits 7:0). Byte 0 is the first byte received. An individual address (byte 0 bit 0 clear) is accepted only when all 48 bits equal this station address.
- R4: Select 4 writes the mode. Bit 1 is broadcast reject. While it is set, the all-ones address is rejected. While it is clear, the all-ones address is accepted.
- R5: A group address that is not broadcast is decided only by the hash table. Select 2 loads table bits 31:0 and select 3 loads bits 63:32. The bin is CRC bits 31:26 of the Ethernet CRC-32 (polynomial 0x04C11DB7, all-ones seed, bits of each byte taken least significant first, no final inversion) over the six address bytes. Bin bit 5 picks the high word and bits 4:0 pick the bit within it.
- R6: Mode bit 0 is promiscuous. While it is set every frame is accepted, broadcast reject included.
- R7: With both hash words all ones, every group address is accepted.
- R8: `byte_sof` always restarts collection with that byte as byte 0, even in the middle of a frame. The CRC restarts with it.
- R9: Writes with select values 5 to 7 change no register.
- R10: A register write in the same cycle as the sixth byte does not affect that frame's verdict. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0..4 used) |
| cfg_wdata | input | 32 | Register write data |
| byte_vld | input | 1 | Destination byte present |
| byte_sof | input | 1 | Marks the first destination byte |
| byte_data | input | 8 | Destination byte |
| dec_vld | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop (valid with dec_vld) |

## Verification
The bench builds the filter with its default parameters: six address bytes and 32-bit registers. That gives a 64-bin table split over two words, so group addresses landing in both halves can be reached by choosing addresses and letting the bench's own CRC find their bins. With the table loaded with a single bin, and then with its complement, each lookup is shown to hit and to miss. The same geometry lets a frame differ from the station address in the first or the last byte only, and lets a register write be placed on the sixth byte of a frame.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;
   localparam int CRC_W = 32;
   localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [CRC_W-1:0] CRC_SEED      = '1;

   typedef enum logic [2:0] {
      SEL_STA_LO  = 3'd0,
      SEL_STA_HI  = 3'd1,
      SEL_HASH_LO = 3'd2,
      SEL_HASH_HI = 3'd3,
      SEL_MODE    = 3'd4
   } cfg_sel_e;

   typedef struct packed {
      logic bcast_rej;
      logic promisc;
   } mode_t;
endpackage

// File: rtl/da_crc_byte.sv
module da_crc_byte
   import rx_da_pkg::*;
(
   input  logic [CRC_W-1:0] crc_in,
   input  logic [7:0]       data,
   output logic [CRC_W-1:0] crc_out
);
   logic [8:0][CRC_W-1:0] stage;

   assign stage[0] = crc_in;

   for (genvar gi = 0; gi < 8; gi++) begin : g_bit
      assign stage[gi+1] = (stage[gi][0] ^ data[gi])
                         ? ((stage[gi] >> 1) ^ CRC_POLY_REFL)
                         :  (stage[gi] >> 1);
   end

   assign crc_out = stage[8];
endmodule

// File: rtl/da_cfg_regs.sv
module da_cfg_regs
   import rx_da_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int HI_W   = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       sel,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] sta_lo,
   output logic [HI_W-1:0]  sta_hi,
   output logic [REG_W-1:0] hash_lo,
   output logic [REG_W-1:0] hash_hi,
   output mode_t            mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sta_lo  <= '0;
         sta_hi  <= '0;
         hash_lo <= '0;
         hash_hi <= '0;
         mode    <= '0;
      end else if (we) begin
         case (sel)
            SEL_STA_LO:  sta_lo  <= wdata;
            SEL_STA_HI:  sta_hi  <= wdata[HI_W-1:0];
            SEL_HASH_LO: hash_lo <= wdata;
            SEL_HASH_HI: hash_hi <= wdata;
            SEL_MODE: begin
               mode.promisc   <= wdata[0];
               mode.bcast_rej <= wdata[1];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/da_addr_collect.sv
module da_addr_collect
   import rx_da_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W      = 6
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_vld,
   input  logic                    byte_sof,
   input  logic [7:0]              byte_data,
   output logic                    last_byte,
   output logic [ADDR_BYTES*8-1:0] da_full,
   output logic [IDX_W-1:0]        crc_low
);
   localparam int AW = ADDR_BYTES * 8;
   localparam int CW = $clog2(ADDR_BYTES + 1);
   localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES);

   logic [AW-1:0]    da_sh;
   logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;
   logic [CW-1:0]    cnt_q, cnt_nxt;
   logic             take;

   assign take     = byte_vld & (byte_sof | ((cnt_q != '0) && (cnt_q < LAST)));
   assign cnt_nxt  = byte_sof ? CW'(1) : cnt_q + CW'(1);
   assign crc_base = byte_sof ? CRC_SEED : crc_q;
   assign da_full  = {da_sh[AW-9:0], byte_data};
   assign last_byte = take && (cnt_nxt == LAST);
   assign crc_low  = crc_nxt[IDX_W-1:0];

   da_crc_byte u_crc (
      .crc_in  (crc_base),
      .data    (byte_data),
      .crc_out (crc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         da_sh <= '0;
         crc_q <= CRC_SEED;
         cnt_q <= '0;
      end else if (take) begin
         da_sh <= da_full;
         crc_q <= crc_nxt;
         cnt_q <= cnt_nxt;
      end
   end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
   import rx_da_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int REG_W      = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             byte_vld,
   input  logic             byte_sof,
   input  logic [7:0]       byte_data,
   output logic             dec_vld,
   output logic             dec_accept
);
   localparam int AW    = ADDR_BYTES * 8;
   localparam int HI_W  = AW - REG_W;
   localparam int TBL_W = 2 * REG_W;
   localparam int IDX_W = $clog2(TBL_W);

   if (ADDR_BYTES < 2 || AW <= REG_W || AW > TBL_W) begin : g_bad_geom
      $error("rx_da_filter: address must span more than one and at most two registers");
   end
   if ((1 << IDX_W) != TBL_W || IDX_W > CRC_W) begin : g_bad_hash
      $error("rx_da_filter: hash table width must be a power of two within the CRC");
   end

   logic [REG_W-1:0] sta_lo, hash_lo, hash_hi;
   logic [HI_W-1:0]  sta_hi;
   mode_t            mode_q;
   logic             cfg_promisc, cfg_bcrej;
   logic             last_byte;
   logic [AW-1:0]    da_full, station;
   logic [IDX_W-1:0] crc_low, hash_idx;
   logic [TBL_W-1:0] hash_tbl;
   logic             is_bcast, is_group, hash_hit, verdict;
   logic             vld_q, acc_q;

   da_cfg_regs #(.REG_W(REG_W), .HI_W(HI_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .sta_lo  (sta_lo),
      .sta_hi  (sta_hi),
      .hash_lo (hash_lo),
      .hash_hi (hash_hi),
      .mode    (mode_q)
   );

   da_addr_collect #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_sof  (byte_sof),
      .byte_data (byte_data),
      .last_byte (last_byte),
      .da_full   (da_full),
      .crc_low   (crc_low)
   );

   // Reflected CRC bit k lands at bin bit (IDX_W-1-k) after bit reversal.
   for (genvar gk = 0; gk < IDX_W; gk++) begin : g_idx
      assign hash_idx[IDX_W-1-gk] = crc_low[gk];
   end

   assign cfg_promisc = mode_q.promisc;
   assign cfg_bcrej   = mode_q.bcast_rej;
   assign station     = {sta_hi, sta_lo};
   assign hash_tbl    = {hash_hi, hash_lo};
   assign hash_hit    = hash_tbl[hash_idx];
   assign is_bcast    = &da_full;
   assign is_group    = da_full[AW-8] & ~is_bcast;

   always_comb begin
      if (cfg_promisc)   verdict = 1'b1;
      else if (is_bcast) verdict = ~cfg_bcrej;
      else if (is_group) verdict = hash_hit;
      else               verdict = (da_full == station);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         acc_q <= 1'b0;
      end else begin
         vld_q <= last_byte;
         if (last_byte) acc_q <= verdict;
      end
   end

   assign dec_vld    = vld_q;
   assign dec_accept = acc_q;
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk #(
   parameter int AW = 48
)(
   input logic          clk,
   input logic          rst_n,
   input logic          dec_vld,
   input logic          dec_accept,
   input logic          last_byte,
   input logic [AW-1:0] da_full,
   input logic [AW-1:0] station,
   input logic          promisc,
   input logic          bcast_rej
);
   AST_STROBE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> dec_vld); // R2
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld); // R2
   AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !last_byte |=> !dec_vld); // R2
   AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && promisc) |=> dec_accept); // R6
   AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && (&da_full) && bcast_rej && !promisc) |=> !dec_accept); // R4
   AST_UNICAST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !da_full[AW-8] && (da_full != station) && !promisc) |=> !dec_accept); // R3
   AST_UNICAST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !da_full[AW-8] && (da_full == station)) |=> dec_accept); // R3
endmodule

bind rx_da_filter rx_da_filter_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_vld    (dec_vld),
   .dec_accept (dec_accept),
   .last_byte  (last_byte),
   .da_full    (da_full),
   .station    (station),
   .promisc    (cfg_promisc),
   .bcast_rej  (cfg_bcrej)
);

// File: tb/rx_da_filter_bench.sv
module rx_da_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        byte_vld = 1'b0;
   logic        byte_sof = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        dec_vld, dec_accept;

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   bit    done = 0;
   int    hand = -1;
   string tag = "R1 idle";

   always #2.5 clk = ~clk;

   rx_da_filter u_rx_da_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .byte_vld(byte_vld), .byte_sof(byte_sof),
      .byte_data(byte_data), .dec_vld(dec_vld), .dec_accept(dec_accept)
   );

   task automatic check(bit ok, string t, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   function automatic bit [5:0] bin_of(bit [47:0] a);
      bit [31:0] c = '1;
      for (int b = 0; b < 6; b++) begin
         bit [7:0] v = a[47-8*b -: 8];
         for (int i = 0; i < 8; i++) begin
            bit fb = c[31] ^ v[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c[31:26];
   endfunction

   // reference model state
   bit [31:0] m_slo, m_shi, m_hlo, m_hhi;
   bit        m_prom, m_brej;
   bit [47:0] m_sh;
   int        m_cnt;
   bit        exp_vld, exp_acc;
   int        exp_hand;
   string     exp_tag = "R1 idle";

   function automatic bit model_decide(bit [47:0] a);
      bit [63:0] tbl = {m_hhi, m_hlo};
      if (m_prom) return 1;
      if (a == 48'hFFFF_FFFF_FFFF) return !m_brej;
      if (a[40]) return tbl[bin_of(a)];
      return a == {m_shi[15:0], m_slo};
   endfunction

   always @(posedge clk) begin
      exp_vld = 0;
      if (!rst_n) begin
         m_slo = 0; m_shi = 0; m_hlo = 0; m_hhi = 0; m_prom = 0; m_brej = 0;
         m_cnt = 0;
      end else begin
         if (byte_vld) begin
            if (byte_sof) begin
               m_sh = {40'd0, byte_data}; m_cnt = 1;
            end else if (m_cnt > 0 && m_cnt < 6) begin
               m_sh = {m_sh[39:0], byte_data}; m_cnt++;
               if (m_cnt == 6) begin
                  exp_vld = 1; exp_acc = model_decide(m_sh);
                  exp_hand = hand; exp_tag = tag;
               end
            end
         end
         if (cfg_we) begin
            case (cfg_sel)
               3'd0: m_slo = cfg_wdata;
               3'd1: m_shi = {16'd0, cfg_wdata[15:0]};
               3'd2: m_hlo = cfg_wdata;
               3'd3: m_hhi = cfg_wdata;
               3'd4: begin m_prom = cfg_wdata[0]; m_brej = cfg_wdata[1]; end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (exp_vld) begin
            check(dec_vld === 1'b1, {exp_tag, " strobe"}, dec_vld, 1);
            check(dec_accept === exp_acc, {exp_tag, " model"}, dec_accept, exp_acc);
            if (exp_hand >= 0)
               check(dec_accept === exp_hand[0], {exp_tag, " expected"}, dec_accept, exp_hand);
         end else if (dec_vld !== 1'b0) begin
            check(0, "R2 stray strobe", dec_vld, 0);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !done) begin
         done = 1;
         check(0, "R2 watchdog expired", cyc, 60000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wr(int sel, bit [31:0] d);
      cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic frame(bit [47:0] a, int h, string t, int gap = 0, int extra = 0,
                        bit lw = 0, int lsel = 0, bit [31:0] ldat = 0);
      hand = h; tag = t;
      for (int i = 0; i < 6; i++) begin
         byte_vld = 1; byte_sof = (i == 0); byte_data = a[47-8*i -: 8];
         if (i == 5 && lw) begin cfg_we = 1; cfg_sel = 3'(lsel); cfg_wdata = ldat; end
         @(posedge clk); #1;
         cfg_we = 0;
         byte_vld = 0; byte_sof = 0;
         repeat (gap) @(posedge clk);
         if (gap > 0) #1;
      end
      for (int i = 0; i < extra; i++) begin
         byte_vld = 1; byte_data = 8'hFF;
         @(posedge clk); #1;
      end
      byte_vld = 0;
      repeat (3) @(posedge clk);
      #1;
   endtask

   localparam bit [47:0] STA   = 48'h0211_2233_4455;
   localparam bit [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check(dec_vld === 1'b0, "R1 reset strobe low", dec_vld, 0);
      check(dec_accept === 1'b0, "R1 reset verdict low", dec_accept, 0);
      @(posedge clk); #1;

      frame(48'h0, 1, "R1 zero station match");
      frame(BCAST, 1, "R1 broadcast at reset");
      frame(48'h0100_5E00_0001, 0, "R1 empty hash");

      wr(0, 32'h2233_4455); wr(1, 32'hABCD_0211);
      frame(STA, 1, "R3 station match");
      frame(48'h0011_2233_4455, 0, "R3 first byte differs");
      frame(48'h0211_2233_4454, 0, "R3 last bit differs");
      frame(48'h0000_2233_4455, 0, "R3 high word differs");

      frame(BCAST, 1, "R4 broadcast allowed");
      wr(4, 32'h2);
      frame(BCAST, 0, "R4 broadcast rejected");
      wr(4, 32'h0);

      for (int k = 0; k < 8; k++) begin
         bit [47:0] a = (k < 4) ? (48'h0100_5E00_0000 | 48'(k * 37 + 1))
                                : (48'h3333_0000_0000 | 48'(k * 91));
         bit [5:0] b = bin_of(a);
         bit [31:0] one = 32'h1 << b[4:0];
         if (b[5]) begin wr(3, one); wr(2, 0); end
         else      begin wr(2, one); wr(3, 0); end
         frame(a, 1, "R5 hash bin hit");
         if (b[5]) begin wr(3, ~one); wr(2, '1); end
         else      begin wr(2, ~one); wr(3, '1); end
         frame(a, 0, "R5 hash bin miss");
      end

      wr(2, '1); wr(3, '1);
      frame(48'h0100_5E7F_FFFA, 1, "R7 all bins group a");
      frame(48'hC300_0000_0001, 1, "R7 all bins group b");
      frame(48'h0211_2233_4456, 0, "R7 unicast unaffected");

      wr(2, 0); wr(3, 0); wr(4, 32'h3);
      frame(48'h0611_2233_4400, 1, "R6 promisc unicast");
      frame(48'h0100_5E00_0009, 1, "R6 promisc group");
      frame(BCAST, 1, "R6 promisc over broadcast reject");
      wr(4, 32'h0);

      frame(STA, 1, "R2 gapped bytes", 2, 0);
      frame(STA, 1, "R2 trailing bytes ignored", 0, 9);

      hand = -1; tag = "R8 partial frame";
      for (int i = 0; i < 3; i++) begin
         byte_vld = 1; byte_sof = (i == 0); byte_data = 8'h01 + 8'(i);
         @(posedge clk); #1;
      end
      byte_vld = 0; byte_sof = 0;
      frame(STA, 1, "R8 restart on sof");

      wr(5, 32'hFFFF_FFFF); wr(6, 32'h0000_0003); wr(7, 32'hFFFF_FFFF);
      frame(STA, 1, "R9 unused select station kept");
      frame(BCAST, 1, "R9 unused select mode kept");
      frame(48'h0100_5E00_0001, 0, "R9 unused select hash kept");

      frame(STA, 1, "R10 write on last byte", 0, 0, 1, 0, 32'h0);
      frame(STA, 0, "R10 write applies next");

      repeat (4) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule